// File: doc/BRIEF.md
# Pad Pull Mode Controller

This block turns the configuration of one general-purpose pad into the three controls that the pad cell needs: a pull-up enable, a pull-down enable and an open-drain drive control. A 2-bit pull mode field selects no pull, pull-down, pull-up or a repeater (keeper) mode. In repeater mode the pad's own sensed level chooses the pull, so an input that nobody drives keeps the last level it had instead of floating.

The pull mode field is loaded from two per-pad non-volatile configuration bits while reset is held, and software can rewrite it through a one-cycle write strobe once reset is released. Two flags from outside override the field: an analog-select flag from the pin function multiplexer switches both pulls off, and an I2C-pad flag forces true open-drain drive whatever function is selected. On ordinary digital pads the open-drain enable input chooses open-drain drive.

The sensed pad level passes through a synchronizer of `SYNC_STAGES` flops (two by default) before it steers the repeater, so the pull choice follows a settled copy of the pad and cannot chase its own effect within a cycle.

Top module: `pad_pull_ctrl`

## Requirements
- R1: While `rst` is high, each rising clock edge loads the mode field from `nvm_mode_i`; `mode_o` shows the field.
- R2: With `rst` low, a rising edge with `cfg_we_i` high stores `cfg_mode_i` into the field; without the strobe the field keeps its value.
- R3: Mode encodings on a digital pad: 2'b00 drives both pull enables low, 2'b01 drives only `pull_dn_en_o` high, 2'b10 drives only `pull_up_en_o` high.
- R4: In mode 2'b11 (repeater) `pull_up_en_o` is high when the synchronized pad level is 1 and `pull_dn_en_o` is high when it is 0; a change of `pad_level_i` reaches the pull enables after two rising edges, and the synchronized level is 0 after reset.
- R5: When `analog_sel_i` is high, both pull enables are low in every mode.
- R6: On a pad with `i2c_pad_i` low, `od_drive_o` equals `od_en_i` while `analog_sel_i` is low and is 0 while `analog_sel_i` is high.
- R7: When `i2c_pad_i` is high, `od_drive_o` is 1 regardless of `od_en_i`, `analog_sel_i` and the mode.
- R8: `pull_up_en_o` and `pull_dn_en_o` are never high together.
- R9: A write strobe during reset has no effect: the field takes `nvm_mode_i`, not `cfg_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_level_i | input | 1 | Sensed pad input level (asynchronous) |
| nvm_mode_i | input | 2 | Reset default of the pull mode field |
| cfg_we_i | input | 1 | Software write strobe for the mode field |
| cfg_mode_i | input | 2 | Mode value to write |
| od_en_i | input | 1 | Open-drain enable for a digital pad |
| analog_sel_i | input | 1 | Pin function multiplexer selected an analog function |
| i2c_pad_i | input | 1 | Pad is a dedicated I2C pad |
| mode_o | output | 2 | Current pull mode field |
| pull_up_en_o | output | 1 | Pull-up resistor enable |
| pull_dn_en_o | output | 1 | Pull-down resistor enable |
| od_drive_o | output | 1 | Open-drain drive control |

## Verification
On every cycle the assertions check that the two pull enables are exclusive, that analog selection leaves both off, that the I2C flag always yields open-drain drive, that the field takes the non-volatile default under reset, takes written data only after reset and otherwise holds, and that repeater mode always keeps exactly one pull on. Only the bench scenarios show the value mapping of each encoding, the two-edge latency with which the repeater follows the pad in both directions, the pull-down choice right after reset, and that a write during reset is lost.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_NONE = 2'b00,
        PM_DOWN = 2'b01,
        PM_UP   = 2'b10,
        PM_KEEP = 2'b11
    } pull_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pull_ctl_t;

    typedef struct packed {
        logic analog;
        logic i2c;
        logic od_en;
    } pad_flags_t;

    // Pull selection for a digital pad from the mode and the settled level.
    function automatic pull_ctl_t pull_select(pull_mode_e mode, logic lvl);
        pull_ctl_t c;
        c = '0;
        case (mode)
            PM_DOWN: c.dn = 1'b1;
            PM_UP:   c.up = 1'b1;
            PM_KEEP: begin
                c.up = lvl;
                c.dn = ~lvl;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic od_select(pad_flags_t f);
        return f.i2c | (f.od_en & ~f.analog);
    endfunction

endpackage

// File: rtl/pad_mode_reg.sv
module pad_mode_reg
    import pad_pull_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pull_mode_e  nvm_mode,
    input  logic        wr_en,
    input  pull_mode_e  wr_mode,
    output pull_mode_e  mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= nvm_mode;
        end else if (wr_en) begin
            mode_q <= wr_mode;
        end
    end

    // R1 and R9: reset loads the default, a strobe under reset is lost.
    a_r1_reset_load: assert property (@(posedge clk)
        $past(rst) |-> mode_q == $past(nvm_mode));

    // R2: a write after reset lands in the field.
    a_r2_write: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en)) |-> mode_q == $past(wr_mode));

    // R2: without a strobe the field holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!wr_en)) |-> $stable(mode_q));

endmodule

// File: rtl/pad_level_sync.sv
module pad_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic level_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= level_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign level_o = chain_q[LAST];

    // R4: the settled level is low in the cycle after reset.
    a_r4_sync_reset: assert property (@(posedge clk)
        $past(rst) |-> !level_o);

endmodule

// File: rtl/pad_pull_decode.sv
module pad_pull_decode
    import pad_pull_pkg::*;
(
    input  pull_mode_e  mode,
    input  logic        level_sync,
    input  pad_flags_t  flags,
    output pull_ctl_t   pull,
    output logic        od_drive
);

    pull_ctl_t digital_pull;

    always_comb begin
        digital_pull = pull_select(mode, level_sync);
        pull         = flags.analog ? '0 : digital_pull;
        od_drive     = od_select(flags);
    end

    // R8: never both pulls at once.
    always_comb begin
        a_r8_exclusive: assert (!(pull.up && pull.dn));
    end

endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
    import pad_pull_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pad_level_i,
    input  logic [MODE_W-1:0] nvm_mode_i,
    input  logic              cfg_we_i,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              od_en_i,
    input  logic              analog_sel_i,
    input  logic              i2c_pad_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              pull_up_en_o,
    output logic              pull_dn_en_o,
    output logic              od_drive_o
);

    pull_mode_e mode_q;
    logic       level_sync;
    pad_flags_t flags;
    pull_ctl_t  pull;

    assign flags = '{analog: analog_sel_i, i2c: i2c_pad_i, od_en: od_en_i};

    pad_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .nvm_mode (pull_mode_e'(nvm_mode_i)),
        .wr_en    (cfg_we_i),
        .wr_mode  (pull_mode_e'(cfg_mode_i)),
        .mode_q   (mode_q)
    );

    pad_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .level_i (pad_level_i),
        .level_o (level_sync)
    );

    pad_pull_decode u_dec (
        .mode       (mode_q),
        .level_sync (level_sync),
        .flags      (flags),
        .pull       (pull),
        .od_drive   (od_drive_o)
    );

    assign mode_o       = mode_q;
    assign pull_up_en_o = pull.up;
    assign pull_dn_en_o = pull.dn;

    // R5: analog selection leaves the pad unpulled.
    a_r5_analog_off: assert property (@(posedge clk) disable iff (rst)
        analog_sel_i |-> (!pull_up_en_o && !pull_dn_en_o));

    // R7: dedicated I2C pads always drive open-drain.
    a_r7_i2c_od: assert property (@(posedge clk) disable iff (rst)
        i2c_pad_i |-> od_drive_o);

    // R4: repeater on a digital pad always holds exactly one pull.
    a_r4_keep_one: assert property (@(posedge clk) disable iff (rst)
        (mode_o == PM_KEEP && !analog_sel_i)
            |-> $countones({pull_up_en_o, pull_dn_en_o}) == 1);

    // R8: exclusivity seen at the ports.
    a_r8_ports: assert property (@(posedge clk) disable iff (rst)
        !(pull_up_en_o && pull_dn_en_o));

endmodule

// File: tb/pad_pull_ctrl_bench.sv
module pad_pull_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pad_level_i = 1'b0;
    logic [1:0] nvm_mode_i = 2'b10;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_mode_i = 2'b00;
    logic       od_en_i = 1'b0;
    logic       analog_sel_i = 1'b0;
    logic       i2c_pad_i = 1'b0;
    logic [1:0] mode_o;
    logic       pull_up_en_o;
    logic       pull_dn_en_o;
    logic       od_drive_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pad_pull_ctrl u_pad_pull_ctrl (
        .clk(clk), .rst(rst), .pad_level_i(pad_level_i),
        .nvm_mode_i(nvm_mode_i), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
        .od_en_i(od_en_i), .analog_sel_i(analog_sel_i), .i2c_pad_i(i2c_pad_i),
        .mode_o(mode_o), .pull_up_en_o(pull_up_en_o),
        .pull_dn_en_o(pull_dn_en_o), .od_drive_o(od_drive_o)
    );

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Packs {pull_up, pull_dn} for comparisons.
    function automatic logic [3:0] pulls();
        return {2'b00, pull_up_en_o, pull_dn_en_o};
    endfunction

    task automatic write_mode(logic [1:0] m);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_mode_i = m;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        nvm_mode_i = 2'b10;
        cfg_we_i = 1'b1;
        cfg_mode_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R1", {2'b00, mode_o}, 4'h2);
        check("R9", {2'b00, mode_o}, 4'h2);
        cfg_we_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", {2'b00, mode_o}, 4'h2);
        check("R3", pulls(), 4'h2);
    endtask

    task automatic t_reset_keep();
        @(negedge clk);
        rst = 1'b1;
        nvm_mode_i = 2'b11;
        pad_level_i = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {2'b00, mode_o}, 4'h3);
        // one edge after reset the settled level is still the reset zero
        check("R4", pulls(), 4'h1);
        @(negedge clk);
        check("R4", pulls(), 4'h2);
    endtask

    task automatic t_static_modes();
        write_mode(2'b00);
        check("R2", {2'b00, mode_o}, 4'h0);
        check("R3", pulls(), 4'h0);
        write_mode(2'b01);
        check("R3", pulls(), 4'h1);
        write_mode(2'b10);
        check("R3", pulls(), 4'h2);
        repeat (3) @(negedge clk);
        check("R2", {2'b00, mode_o}, 4'h2);
    endtask

    task automatic t_repeater();
        pad_level_i = 1'b0;
        write_mode(2'b11);
        repeat (2) @(negedge clk);
        check("R4", pulls(), 4'h1);
        pad_level_i = 1'b1;
        @(negedge clk);
        check("R4", pulls(), 4'h1);
        check("R8", {3'b000, pull_up_en_o & pull_dn_en_o}, 4'h0);
        @(negedge clk);
        check("R4", pulls(), 4'h2);
        pad_level_i = 1'b0;
        @(negedge clk);
        check("R4", pulls(), 4'h2);
        @(negedge clk);
        check("R4", pulls(), 4'h1);
    endtask

    task automatic t_analog();
        analog_sel_i = 1'b1;
        for (int m = 0; m < 4; m++) begin
            write_mode(m[1:0]);
            check("R5", pulls(), 4'h0);
        end
        od_en_i = 1'b1;
        #0;
        check("R6", {3'b000, od_drive_o}, 4'h0);
        analog_sel_i = 1'b0;
        write_mode(2'b10);
        check("R5", pulls(), 4'h2);
    endtask

    task automatic t_open_drain();
        @(negedge clk);
        i2c_pad_i = 1'b0;
        od_en_i = 1'b0;
        #1 check("R6", {3'b000, od_drive_o}, 4'h0);
        od_en_i = 1'b1;
        #1 check("R6", {3'b000, od_drive_o}, 4'h1);
        od_en_i = 1'b0;
        i2c_pad_i = 1'b1;
        #1 check("R7", {3'b000, od_drive_o}, 4'h1);
        analog_sel_i = 1'b1;
        #1 check("R7", {3'b000, od_drive_o}, 4'h1);
        analog_sel_i = 1'b0;
        i2c_pad_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_static_modes();
        t_repeater();
        t_analog();
        t_open_drain();
        t_reset_keep();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule